// File: doc/BRIEF.md
# DRAM Idle Page-Close Controller

This block keeps the open-row state of every bank in a DRAM controller. It sorts each incoming request by that state. A request to the row already open in its bank is a hit, and nothing more is needed. A request to a bank with no open row is a miss, and the row is activated at once. A request to a bank holding a different row is a conflict, so the old row is precharged first and the new row is activated after that. Activate and precharge requests go to a command issuer, and each one is held until that issuer acknowledges it.

While the block sits idle with at least one row open, it counts consecutive idle cycles. When the count reaches a limit chosen by a 3-bit setting, it closes every open page ahead of need with a single all-bank precharge. One setting turns this early close off. A refresh request also closes every open page, whatever the count and whatever the setting. Requests that arrive while a precharge or an activate is in progress are stalled until that work is acknowledged.

Top module: `idle_page_closer`

## Requirements
- R1: After reset, no bank is open, no activate or precharge request is raised, no classification is reported and `req_ready` is 1.
- R2: `limit_sel` sets the idle limit N: code 0 gives 0, code 1 gives 16, code 2 gives 32, code 3 gives 64, code 4 gives 96, code 5 means never close on idle, and codes 6 and 7 give the default of 16.
- R3: A request accepted for the row already open in its bank is reported in that cycle as `cls_kind` = 1 (hit), with `cls_valid` high. No activate or precharge follows it.
- R4: A request accepted for a bank with no open row is reported as `cls_kind` = 2 (miss). In the next cycle `act_req` rises with that bank and row and stays high until `act_ack`. After that, the bank shows as open with that row.
- R5: A request accepted for a bank holding a different row is reported as `cls_kind` = 3 (conflict). A single-bank precharge (`pre_req` = 1, `pre_all` = 0, `pre_bank` = that bank) is raised next and held until `pre_ack`. Then the activate of the new row follows as in R4.
- R6: With limit N and at least one bank open, the block counts consecutive cycles in which it is ready and sees no request. In the cycle after the max(N,1)-th such cycle it raises `pre_req` with `pre_all` = 1. With no bank open, no idle precharge is raised.
- R7: With code 5 selected, the idle count never raises a precharge. Open pages stay open until a conflict or a refresh closes them.
- R8: A `refresh_req` pulse raises an all-bank precharge whenever any bank is open, whatever the idle count. When no bank is open it raises no precharge. After the acknowledge of an all-bank precharge, every bank shows as closed.
- R9: Every accepted request restarts the idle count from zero.
- R10: While an activate or precharge is pending, `req_ready` is 0. Open flags drop only on `pre_ack`, so banks still show as open while the precharge waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 14 | Row of the request |
| req_ready | output | 1 | Request accepted this cycle when valid |
| limit_sel | input | 3 | Idle limit code (R2) |
| refresh_req | input | 1 | Refresh pulse, forces all pages closed |
| cls_valid | output | 1 | Classification reported this cycle |
| cls_kind | output | 2 | 1 hit, 2 miss, 3 conflict, 0 none |
| act_req | output | 1 | Activate request |
| act_bank | output | 2 | Bank to activate |
| act_row | output | 14 | Row to activate |
| act_ack | input | 1 | Activate issued |
| pre_req | output | 1 | Precharge request |
| pre_all | output | 1 | Precharge targets all banks |
| pre_bank | output | 2 | Bank of a single-bank precharge |
| pre_ack | input | 1 | Precharge issued |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 56 | Per-bank open row, bank i at bits 14*i and up |

## Verification
The case that is hardest to reach is an idle close at the far end of the limit range. To get there, a row has to be opened and then the block has to be left completely quiet for 96 cycles, with no request and no refresh anywhere in the window. The stimulus does this with a scripted miss followed by a counted run of idle cycles, and it repeats that for every code. A second run stops partway through the window with a hit, to show that the count starts again. Refresh is driven both with banks open and with every bank closed, to cover the case where it must raise nothing.

// File: rtl/idle_close_pkg.sv
package idle_close_pkg;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_HIT  = 2'd1,
      CLS_MISS = 2'd2,
      CLS_CONF = 2'd3
   } cls_e;

   typedef enum logic [1:0] {
      ST_READY   = 2'd0,
      ST_PRE_ONE = 2'd1,
      ST_ACT     = 2'd2,
      ST_PRE_ALL = 2'd3
   } ctl_state_e;

   localparam logic [2:0] LIMIT_CODE_NEVER = 3'd5;

endpackage

// File: rtl/ipc_limit_decode.sv
module ipc_limit_decode #(
   parameter int CNT_W    = 7,
   parameter int LIM_1    = 16,
   parameter int LIM_2    = 32,
   parameter int LIM_3    = 64,
   parameter int LIM_4    = 96,
   parameter int LIM_DFLT = 16
) (
   input  logic [2:0]       code,
   output logic [CNT_W-1:0] limit,
   output logic             never
);
   import idle_close_pkg::*;

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (LIM_1 > CNT_MAX || LIM_2 > CNT_MAX || LIM_3 > CNT_MAX ||
       LIM_4 > CNT_MAX || LIM_DFLT > CNT_MAX) begin : g_bad_width
      $error("ipc_limit_decode: a limit does not fit in CNT_W bits");
   end

   always_comb begin
      never = 1'b0;
      unique case (code)
         3'd0:             limit = '0;
         3'd1:             limit = CNT_W'(LIM_1);
         3'd2:             limit = CNT_W'(LIM_2);
         3'd3:             limit = CNT_W'(LIM_3);
         3'd4:             limit = CNT_W'(LIM_4);
         LIMIT_CODE_NEVER: begin
            limit = CNT_W'(CNT_MAX);
            never = 1'b1;
         end
         default:          limit = CNT_W'(LIM_DFLT);
      endcase
   end

endmodule

// File: rtl/ipc_idle_counter.sv
module ipc_idle_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             reached
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_plus;

   assign cnt_plus = {1'b0, cnt_q} + 1'b1;
   // true on the idle cycle that completes the limit (limit 0: any idle cycle)
   assign reached  = tick && (cnt_plus >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q < limit)) begin
         cnt_q <= cnt_plus[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/ipc_bank_slot.sv
module ipc_bank_slot #(
   parameter int ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic [ROW_W-1:0] open_row,
   input  logic             close,
   output logic             is_open,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row     <= '0;
      end else if (close) begin
         is_open <= 1'b0;
      end else if (open_set) begin
         is_open <= 1'b1;
         row     <= open_row;
      end
   end

endmodule

// File: rtl/idle_page_closer.sv
module idle_page_closer #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 14,
   parameter int CNT_W     = 7,
   parameter int LIM_1     = 16,
   parameter int LIM_2     = 32,
   parameter int LIM_3     = 64,
   parameter int LIM_4     = 96,
   parameter int LIM_DFLT  = 16,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [BANK_W-1:0]          req_bank,
   input  logic [ROW_W-1:0]           req_row,
   output logic                       req_ready,
   input  logic [2:0]                 limit_sel,
   input  logic                       refresh_req,
   output logic                       cls_valid,
   output logic [1:0]                 cls_kind,
   output logic                       act_req,
   output logic [BANK_W-1:0]          act_bank,
   output logic [ROW_W-1:0]           act_row,
   input  logic                       act_ack,
   output logic                       pre_req,
   output logic                       pre_all,
   output logic [BANK_W-1:0]          pre_bank,
   input  logic                       pre_ack,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
   import idle_close_pkg::*;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("idle_page_closer: NUM_BANKS must be a power of two, at least 2");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("idle_page_closer: ROW_W must be positive");
   end

   ctl_state_e              state_q, state_d;
   logic [BANK_W-1:0]       hold_bank_q;
   logic [ROW_W-1:0]        hold_row_q;
   logic                    refresh_pend;
   logic                    any_open;
   logic [ROW_W-1:0]        slot_row [NUM_BANKS];
   logic                    sel_open;
   logic                    sel_hit;
   logic                    accept;
   logic                    idle_tick;
   logic                    idle_reached;
   logic                    idle_fire;
   logic                    close_all_done;
   logic                    pend_clear;
   logic                    cnt_clear;
   logic [CNT_W-1:0]        limit_val;
   logic                    limit_never;
   logic [NUM_BANKS-1:0]    slot_set;
   logic [NUM_BANKS-1:0]    slot_close;

   // ---------------- per-bank open-row slots ----------------
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
      assign slot_set[b]   = (state_q == ST_ACT) && act_ack &&
                             (hold_bank_q == BANK_W'(b));
      assign slot_close[b] = close_all_done ||
                             ((state_q == ST_PRE_ONE) && pre_ack &&
                              (hold_bank_q == BANK_W'(b)));

      ipc_bank_slot #(.ROW_W(ROW_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .open_set (slot_set[b]),
         .open_row (hold_row_q),
         .close    (slot_close[b]),
         .is_open  (bank_open[b]),
         .row      (slot_row[b])
      );

      assign bank_row[b*ROW_W +: ROW_W] = slot_row[b];
   end

   assign any_open = |bank_open;

   // ---------------- limit decode and idle counting ----------------
   ipc_limit_decode #(
      .CNT_W    (CNT_W),
      .LIM_1    (LIM_1),
      .LIM_2    (LIM_2),
      .LIM_3    (LIM_3),
      .LIM_4    (LIM_4),
      .LIM_DFLT (LIM_DFLT)
   ) u_dec (
      .code  (limit_sel),
      .limit (limit_val),
      .never (limit_never)
   );

   assign req_ready      = (state_q == ST_READY) && !refresh_pend;
   assign accept         = req_valid && req_ready;
   assign idle_tick      = req_ready && !req_valid;
   assign close_all_done = (state_q == ST_PRE_ALL) && pre_ack;
   assign cnt_clear      = accept || close_all_done;

   ipc_idle_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cnt_clear),
      .tick    (idle_tick),
      .limit   (limit_val),
      .reached (idle_reached)
   );

   assign idle_fire = idle_reached && any_open && !limit_never;

   // ---------------- classification ----------------
   assign sel_open  = bank_open[req_bank];
   assign sel_hit   = sel_open && (slot_row[req_bank] == req_row);
   assign cls_valid = accept;

   always_comb begin
      cls_kind = CLS_NONE;
      if (accept) begin
         if (sel_hit)       cls_kind = CLS_HIT;
         else if (sel_open) cls_kind = CLS_CONF;
         else               cls_kind = CLS_MISS;
      end
   end

   // ---------------- refresh pending flag ----------------
   assign pend_clear = close_all_done ||
                       ((state_q == ST_READY) && refresh_pend && !any_open);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         refresh_pend <= 1'b0;
      end else begin
         refresh_pend <= (refresh_pend || refresh_req) && !pend_clear;
      end
   end

   // ---------------- control sequence ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_READY: begin
            if (accept) begin
               if (sel_hit)       state_d = ST_READY;
               else if (sel_open) state_d = ST_PRE_ONE;
               else               state_d = ST_ACT;
            end else if (refresh_pend) begin
               if (any_open) state_d = ST_PRE_ALL;
            end else if (idle_fire) begin
               state_d = ST_PRE_ALL;
            end
         end
         ST_PRE_ONE: if (pre_ack) state_d = ST_ACT;
         ST_ACT:     if (act_ack) state_d = ST_READY;
         ST_PRE_ALL: if (pre_ack) state_d = ST_READY;
         default:    state_d = ST_READY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_READY;
         hold_bank_q <= '0;
         hold_row_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            hold_bank_q <= req_bank;
            hold_row_q  <= req_row;
         end
      end
   end

   assign act_req  = (state_q == ST_ACT);
   assign act_bank = hold_bank_q;
   assign act_row  = hold_row_q;
   assign pre_req  = (state_q == ST_PRE_ONE) || (state_q == ST_PRE_ALL);
   assign pre_all  = (state_q == ST_PRE_ALL);
   assign pre_bank = hold_bank_q;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 14,
   parameter int BANK_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [BANK_W-1:0]    req_bank,
   input logic [ROW_W-1:0]     req_row,
   input logic                 req_ready,
   input logic [2:0]           limit_sel,
   input logic                 cls_valid,
   input logic [1:0]           cls_kind,
   input logic                 act_req,
   input logic [BANK_W-1:0]    act_bank,
   input logic [ROW_W-1:0]     act_row,
   input logic                 act_ack,
   input logic                 pre_req,
   input logic                 pre_all,
   input logic [BANK_W-1:0]    pre_bank,
   input logic                 pre_ack,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic                 refresh_pend
);
   // R3
   hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_kind == 2'd1) |=> (!act_req && !pre_req));

   // R4
   miss_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_kind == 2'd2) |=>
         (act_req && !pre_req && act_bank == $past(req_bank) && act_row == $past(req_row)));

   // R4
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_req && !act_ack) |=> (act_req && $stable(act_row) && $stable(act_bank)));

   // R5
   conf_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_kind == 2'd3) |=>
         (pre_req && !pre_all && pre_bank == $past(req_bank)));

   // R10
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && !pre_ack) |=> (pre_req && $stable(pre_all)));

   // R10
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req || act_req) |-> !req_ready);

   // R10
   open_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && pre_all) |-> (bank_open != '0));

   // R8
   all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && pre_all && pre_ack) |=> (bank_open == '0));

   // R7
   never_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pre_all) && $past(limit_sel) == 3'd5) |-> $past(refresh_pend));

endmodule

bind idle_page_closer ipc_checker #(
   .NUM_BANKS (NUM_BANKS),
   .ROW_W     (ROW_W),
   .BANK_W    (BANK_W)
) u_ipc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_bank     (req_bank),
   .req_row      (req_row),
   .req_ready    (req_ready),
   .limit_sel    (limit_sel),
   .cls_valid    (cls_valid),
   .cls_kind     (cls_kind),
   .act_req      (act_req),
   .act_bank     (act_bank),
   .act_row      (act_row),
   .act_ack      (act_ack),
   .pre_req      (pre_req),
   .pre_all      (pre_all),
   .pre_bank     (pre_bank),
   .pre_ack      (pre_ack),
   .bank_open    (bank_open),
   .refresh_pend (refresh_pend)
);

// File: tb/idle_page_closer_bench.sv
module idle_page_closer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_bank = '0;
   logic [13:0] req_row = '0;
   logic        req_ready;
   logic [2:0]  limit_sel = 3'd5;
   logic        refresh_req = 1'b0;
   logic        cls_valid;
   logic [1:0]  cls_kind;
   logic        act_req;
   logic [1:0]  act_bank;
   logic [13:0] act_row;
   logic        act_ack = 1'b0;
   logic        pre_req;
   logic        pre_all;
   logic [1:0]  pre_bank;
   logic        pre_ack = 1'b0;
   logic [3:0]  bank_open;
   logic [55:0] bank_row;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   idle_page_closer u_idle_page_closer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
      .req_ready(req_ready), .limit_sel(limit_sel), .refresh_req(refresh_req),
      .cls_valid(cls_valid), .cls_kind(cls_kind),
      .act_req(act_req), .act_bank(act_bank), .act_row(act_row), .act_ack(act_ack),
      .pre_req(pre_req), .pre_all(pre_all), .pre_bank(pre_bank), .pre_ack(pre_ack),
      .bank_open(bank_open), .bank_row(bank_row)
   );

   localparam logic [1:0] K_HIT = 2'd1, K_MISS = 2'd2, K_CONF = 2'd3;

   // {bank, row, expected class}; walked with limit code 5 (no idle close)
   localparam int NVEC = 9;
   localparam logic [17:0] VEC [NVEC] = '{
      {2'd0, 14'h0005, K_MISS},
      {2'd0, 14'h0005, K_HIT},
      {2'd1, 14'h0007, K_MISS},
      {2'd0, 14'h0009, K_CONF},
      {2'd0, 14'h0009, K_HIT},
      {2'd1, 14'h0007, K_HIT},
      {2'd3, 14'h3FFF, K_MISS},
      {2'd1, 14'h0000, K_CONF},
      {2'd3, 14'h3FFF, K_HIT}
   };

   task automatic check(input bit ok, input string req, input int actual, input int expected);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic pulse_act_ack();
      act_ack = 1'b1;
      @(posedge clk); #1;
      act_ack = 1'b0;
   endtask

   task automatic pulse_pre_ack();
      pre_ack = 1'b1;
      @(posedge clk); #1;
      pre_ack = 1'b0;
   endtask

   // full request sequence; ends on a negedge in the ready state
   task automatic do_req(input logic [1:0] b, input logic [13:0] r, input logic [1:0] k);
      @(negedge clk);
      req_valid = 1'b1; req_bank = b; req_row = r;
      #1;
      check(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
      check(cls_valid && cls_kind == k, "R3/R4/R5 class", int'(cls_kind), int'(k));
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      if (k == K_HIT) begin
         check(!act_req && !pre_req, "R3 hit quiet", int'({act_req, pre_req}), 0);
      end else begin
         if (k == K_CONF) begin
            check(pre_req && !pre_all && pre_bank == b, "R5 single precharge",
                  int'({pre_req, pre_all, pre_bank}), int'({1'b1, 1'b0, b}));
            check(!req_ready && bank_open[b], "R10 stall and still open",
                  int'({req_ready, bank_open[b]}), 1);
            pulse_pre_ack();
            @(negedge clk);
         end
         check(act_req && act_bank == b && act_row == r, "R4 activate",
               int'(act_row), int'(r));
         pulse_act_ack();
         @(negedge clk);
         check(bank_open[b] && bank_row[b*14 +: 14] == r, "R4 open row",
               int'(bank_row[b*14 +: 14]), int'(r));
      end
   endtask

   // counts idle cycles from the current negedge until pre_req
   task automatic count_idle(output int n);
      n = 0;
      while (!pre_req && n < 300) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic idle_case(input logic [2:0] code, input int exp_n);
      int n;
      @(negedge clk);
      limit_sel = code;
      do_req(2'd2, 14'h0123 + 14'(code), K_MISS);
      count_idle(n);
      check(n == exp_n, "R2/R6 idle close delay", n, exp_n);
      check(pre_req && pre_all, "R6 all-bank precharge", int'({pre_req, pre_all}), 3);
      check(bank_open != 4'd0, "R10 open until ack", int'(bank_open), 4);
      pulse_pre_ack();
      @(negedge clk);
      check(bank_open == 4'd0 && !pre_req, "R8 closed after ack", int'(bank_open), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      bit quiet;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(bank_open == 4'd0 && !act_req && !pre_req && !cls_valid,
            "R1 reset outputs", int'({bank_open, act_req, pre_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && bank_open == 4'd0, "R1 ready after reset",
            int'(req_ready), 1);

      // table walk: hits, misses, conflicts under never-close (R3 R4 R5)
      for (int i = 0; i < NVEC; i++) begin
         do_req(VEC[i][17:16], VEC[i][15:2], VEC[i][1:0]);
      end

      // R7: long idle with code 5, no precharge
      quiet = 1'b1;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (pre_req) quiet = 1'b0;
      end
      check(quiet && bank_open == 4'b1011, "R7 never idle close", int'(bank_open), 11);

      // R8: refresh closes all open pages
      @(negedge clk);
      refresh_req = 1'b1;
      @(posedge clk); #1;
      refresh_req = 1'b0;
      n = 0;
      @(negedge clk);
      while (!pre_req && n < 5) begin
         n++;
         @(negedge clk);
      end
      check(pre_req && pre_all, "R8 refresh precharge", int'({pre_req, pre_all}), 3);
      check(!req_ready && bank_open == 4'b1011, "R10 held during refresh close",
            int'(bank_open), 11);
      pulse_pre_ack();
      @(negedge clk);
      check(bank_open == 4'd0, "R8 all closed", int'(bank_open), 0);

      // R8: refresh with nothing open raises nothing
      refresh_req = 1'b1;
      @(posedge clk); #1;
      refresh_req = 1'b0;
      quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (pre_req) quiet = 1'b0;
      end
      check(quiet && req_ready, "R8 refresh with no open bank", int'(pre_req), 0);

      // R2 / R6: every limit code
      idle_case(3'd0, 1);
      // R6: nothing open, no idle precharge
      quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (pre_req) quiet = 1'b0;
      end
      check(quiet, "R6 no close with no open bank", int'(pre_req), 0);
      idle_case(3'd1, 16);
      idle_case(3'd2, 32);
      idle_case(3'd3, 64);
      idle_case(3'd4, 96);
      idle_case(3'd6, 16);
      idle_case(3'd7, 16);

      // R9: a hit part-way through restarts the count
      @(negedge clk);
      limit_sel = 3'd1;
      do_req(2'd1, 14'h0AAA, K_MISS);
      quiet = 1'b1;
      for (int i = 0; i < 10; i++) begin
         if (pre_req) quiet = 1'b0;
         @(negedge clk);
      end
      do_req(2'd1, 14'h0AAA, K_HIT);
      count_idle(n);
      check(quiet && n == 16, "R9 count restart", n, 16);
      pulse_pre_ack();
      @(negedge clk);
      check(bank_open == 4'd0, "R9 closed after restart", int'(bank_open), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule